// File: doc/BRIEF.md
# Dual-Mode Processor Counter/Timer Channel

This block is one processor's counter/timer channel. A single mode bit, taken from that processor's position in a shared mode register, selects one of two personalities. In counter mode the channel compares a running count against a programmable limit. On a match it restarts from zero, sets a reached flag and raises a local interrupt. A zero limit turns the match off, and the count then simply wraps. In user mode the same register words become a 63-bit free-running counter. Software can preset it through separate high and low words, start it and stop it, and it never interrupts.

The count moves in steps of 0x200, one step per tick. A tick is one period of `TICK_DIV` clock cycles: 500 ns at the default of 50 cycles at 100 MHz. Software reaches the channel through a word-indexed 32-bit register port. A write commits on the clock edge where `reg_wr_i` is high. Read data is combinational from the current state, and any side effect of a read commits on the edge where `reg_rd_i` is high. A change of the mode bit is detected against a registered copy and applied on the next clock edge. That edge carries the side effects of the transition.

Top module: `dmt_channel`

## Requirements
- R1: After reset the channel is in counter mode with limit 0, count 0, reached flag 0, run bit 1 and `irq_o` low.
- R2: Each tick adds 0x200 to the count, so bits 8..0 of the count are always zero. A tick falls every `TICK_DIV` cycles. The tick phase restarts on every write that loads the count (counter-mode word 0, user-mode words 0 and 1) and on a return to counter mode, and the first tick then lands `TICK_DIV` edges after that write.
- R3: In counter mode with a nonzero limit, a tick whose new count would be at or above the limit sets the count to 0 and sets both the reached flag and `irq_o`. With limit 0 the count wraps to 0 at 0x7FFFFE00, and neither the flag nor the interrupt is set.
- R4: In counter mode, writing word 0 loads the limit as data AND 0x7FFFFE00, clears the count and lowers `irq_o`. Writing word 2 loads the limit with the same mask but leaves the count and the tick phase alone. Writing word 1 has no effect.
- R5: In counter mode, reading word 0 returns the limit (bit 31 = 0) and clears the reached flag and `irq_o`. Reading word 1 returns the count in bits 30..0 and the reached flag in bit 31.
- R6: Writing word 3 records data bit 0 as the run bit in either mode, and word 3 reads back {31'b0, run}. The run bit gates ticks only in user mode. In counter mode the count advances even when the run bit is 0.
- R7: In user mode, reading word 0 returns {reached, count[62:32]} and reading word 1 returns count[31:0]. Neither read changes any state.
- R8: In user mode, writing word 0 loads count[62:32] from data bits 30..0. Writing word 1 loads count[31:0] from data AND 0xFFFFFE00. Both writes clear the reached flag, and counting continues from the loaded value.
- R9: In user mode, a tick that would bring the count to 0x7FFFFFFFFFFFFE00 wraps it to 0 and sets the reached flag. `irq_o` stays low for the whole time the channel is in user mode.
- R10: A change of `user_mode_i` from 0 to 1 takes effect on the next clock edge, not before. That edge lowers `irq_o`, sets the limit to 0x7FFFFE00, keeps the count and the reached flag, and halts counting if the run bit is 0.
- R11: A change of `user_mode_i` from 1 to 0 takes effect on the next clock edge. That edge clears the count and the reached flag, and counting resumes whatever the run bit is.
- R12: Words 4 to 7 read as 0. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| user_mode_i | input | 1 | This processor's bit of the shared mode register (1 = user mode) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (commits read side effects) |
| reg_addr_i | input | 3 | Word index |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` |
| irq_o | output | 1 | Local interrupt, counter mode only |

## Verification
A wrong count or a wrong tick phase shows up on the next read of word 1. In counter mode it also shows up as an interrupt that arrives one tick early or late, so the bench checks `irq_o` on both sides of the expected match edge. A stale mode copy or a missed transition side effect shows up one cycle after the mode bit moves: `irq_o` stays high, the forced limit is missing from word 0, or a halted user count keeps moving. A wrong wrap in user mode shows up as a missing reached bit in word 0 and a carry that does not reach the high word.

// File: rtl/dmt_pkg.sv
// Package: dmt_pkg
// Shared widths, word indices and fixed values for the dual-mode channel.
// Assumes a 32-bit register port and a 63-bit user count.
package dmt_pkg;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 63;
    localparam int LIM_W  = 31;
    localparam int ADDR_W = 3;

    localparam logic [CNT_W-1:0]  STEP     = 63'h200;
    localparam logic [CNT_W-1:0]  USER_MAX = 63'h7FFF_FFFF_FFFF_FE00;
    localparam logic [CNT_W-1:0]  FREE_MAX = 63'h7FFF_FE00;
    localparam logic [LIM_W-1:0]  LIM_FORCE = 31'h7FFF_FE00;
    localparam logic [DATA_W-1:0] LIM_MASK = 32'h7FFF_FE00;
    localparam logic [DATA_W-1:0] LO_MASK  = 32'hFFFF_FE00;

    localparam logic [ADDR_W-1:0] W_HI   = 3'd0;
    localparam logic [ADDR_W-1:0] W_LO   = 3'd1;
    localparam logic [ADDR_W-1:0] W_QLIM = 3'd2;
    localparam logic [ADDR_W-1:0] W_RUN  = 3'd3;
endpackage

// File: rtl/dmt_tick_gen.sv
// Module: dmt_tick_gen
// Produces a one-cycle tick every TICK_DIV clocks. phase_rst_i restarts
// the period, so the first tick lands TICK_DIV edges after the restart.
// Assumes TICK_DIV >= 2.
module dmt_tick_gen #(
    parameter int TICK_DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phase_rst_i,
    output logic tick_o
);
    localparam int PW = $clog2(TICK_DIV);
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] pre_q;

    assign tick_o = (pre_q == LAST);

    // Prescaler: counts clocks within one tick period.
    always_ff @(posedge clk) begin
        if (!rst_n || phase_rst_i) pre_q <= '0;
        else if (tick_o)           pre_q <= '0;
        else                       pre_q <= pre_q + 1'b1;
    end

    p_tick_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/dmt_chan_core.sv
// Module: dmt_chan_core
// Holds the count, limit, reached flag, interrupt, run bit and the
// registered mode copy. It applies ticks, register writes, read side
// effects and mode-change side effects. When the mode bit changes, the
// transition overrides any count or limit write in the same cycle.
// Assumes the count stays below 2**31 in counter mode.
module dmt_chan_core
    import dmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              tick_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              phase_rst_o,
    output logic              mode_q_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [LIM_W-1:0]  lim_o,
    output logic              rch_o,
    output logic              run_o,
    output logic              irq_o
);
    logic             mode_q, run_q, rch_q, irq_q;
    logic [CNT_W-1:0] cnt_q, cnt_n, step;
    logic [LIM_W-1:0] lim_q, lim_n;
    logic             rch_n, irq_n;
    logic             mode_chg;

    assign mode_chg = (mode_i != mode_q);
    assign step     = cnt_q + STEP;

    // Next-state: read clear, tick, register write, then mode transition.
    always_comb begin
        cnt_n = cnt_q;
        lim_n = lim_q;
        rch_n = rch_q;
        irq_n = irq_q;
        phase_rst_o = 1'b0;
        if (!mode_chg && rd_i && !mode_q && addr_i == W_HI) begin
            irq_n = 1'b0;
            rch_n = 1'b0;
        end
        if (tick_i && (!mode_q || run_q)) begin
            if (mode_q) begin
                if (cnt_q >= USER_MAX - STEP) begin
                    cnt_n = '0;
                    rch_n = 1'b1;
                end else begin
                    cnt_n = step;
                end
            end else if (lim_q != '0) begin
                if (step >= {{(CNT_W-LIM_W){1'b0}}, lim_q}) begin
                    cnt_n = '0;
                    rch_n = 1'b1;
                    irq_n = 1'b1;
                end else begin
                    cnt_n = step;
                end
            end else if (step >= FREE_MAX) begin
                cnt_n = '0;
            end else begin
                cnt_n = step;
            end
        end
        if (!mode_chg && wr_i) begin
            case (addr_i)
                W_HI: begin
                    phase_rst_o = 1'b1;
                    if (mode_q) begin
                        cnt_n[CNT_W-1:DATA_W] = wdata_i[LIM_W-1:0];
                        rch_n = 1'b0;
                    end else begin
                        lim_n = LIM_W'(wdata_i & LIM_MASK);
                        cnt_n = '0;
                        irq_n = 1'b0;
                    end
                end
                W_LO: begin
                    if (mode_q) begin
                        cnt_n[DATA_W-1:0] = wdata_i & LO_MASK;
                        rch_n = 1'b0;
                        phase_rst_o = 1'b1;
                    end
                end
                W_QLIM: lim_n = LIM_W'(wdata_i & LIM_MASK);
                default: ;
            endcase
        end
        if (mode_chg) begin
            irq_n = 1'b0;
            if (mode_i) begin
                lim_n = LIM_FORCE;
            end else begin
                cnt_n = '0;
                rch_n = 1'b0;
                phase_rst_o = 1'b1;
            end
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            cnt_q  <= '0;
            lim_q  <= '0;
            rch_q  <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            mode_q <= mode_i;
            cnt_q  <= cnt_n;
            lim_q  <= lim_n;
            rch_q  <= rch_n;
            irq_q  <= irq_n;
        end
    end

    // Run bit: recorded from word 3 in either mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                       run_q <= 1'b1;
        else if (wr_i && addr_i == W_RUN) run_q <= wdata_i[0];
    end

    assign mode_q_o = mode_q;
    assign cnt_o    = cnt_q;
    assign lim_o    = lim_q;
    assign rch_o    = rch_q;
    assign run_o    = run_q;
    assign irq_o    = irq_q;

    p_grain_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q[8:0] == 9'd0);
    p_irq_has_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> rch_q);
    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && !mode_chg && rd_i && addr_i == W_HI && !tick_i) |=> !irq_q);
    p_halted_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && !mode_chg && !run_q && !(wr_i && (addr_i == W_HI || addr_i == W_LO)))
        |=> $stable(cnt_q));
    p_user_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q |-> !irq_q);
    p_enter_user_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_q) |-> (lim_q == LIM_FORCE && !irq_q));
    p_leave_user_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mode_q) |-> (cnt_q == '0 && !rch_q));
endmodule

// File: rtl/dmt_rd_mux.sv
// Module: dmt_rd_mux
// Combinational read-data selection. The meaning of words 0 and 1
// depends on the registered mode. Unmapped words read as zero.
module dmt_rd_mux
    import dmt_pkg::*;
(
    input  logic              mode_q_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [LIM_W-1:0]  lim_i,
    input  logic              rch_i,
    input  logic              run_i,
    output logic [DATA_W-1:0] rdata_o
);
    // Word decode.
    always_comb begin
        case (addr_i)
            W_HI:    rdata_o = mode_q_i ? {rch_i, cnt_i[CNT_W-1:DATA_W]} : {1'b0, lim_i};
            W_LO:    rdata_o = mode_q_i ? cnt_i[DATA_W-1:0] : {rch_i, cnt_i[LIM_W-1:0]};
            W_RUN:   rdata_o = {{(DATA_W-1){1'b0}}, run_i};
            default: rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/dmt_channel.sv
// Module: dmt_channel (top)
// One processor's dual-mode counter/timer channel: tick prescaler,
// state core and read mux. user_mode_i is this processor's bit of the
// shared mode register.
module dmt_channel
    import dmt_pkg::*;
#(
    parameter int TICK_DIV = 50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              user_mode_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [2:0]        reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic              irq_o
);
    logic             tick, phase_rst, mode_q, rch, run;
    logic [CNT_W-1:0] cnt;
    logic [LIM_W-1:0] lim;

    dmt_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .phase_rst_i(phase_rst), .tick_o(tick)
    );

    dmt_chan_core u_core (
        .clk(clk), .rst_n(rst_n), .mode_i(user_mode_i), .tick_i(tick),
        .wr_i(reg_wr_i), .rd_i(reg_rd_i), .addr_i(reg_addr_i),
        .wdata_i(reg_wdata_i), .phase_rst_o(phase_rst), .mode_q_o(mode_q),
        .cnt_o(cnt), .lim_o(lim), .rch_o(rch), .run_o(run), .irq_o(irq_o)
    );

    dmt_rd_mux u_rd (
        .mode_q_i(mode_q), .addr_i(reg_addr_i), .cnt_i(cnt), .lim_i(lim),
        .rch_i(rch), .run_i(run), .rdata_o(reg_rdata_o)
    );
endmodule

// File: tb/tb_dmt_channel.sv
module tb_dmt_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        user_mode = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] d;

    dmt_channel #(.TICK_DIV(4)) dut (
        .clk(clk), .rst_n(rst_n), .user_mode_i(user_mode), .reg_wr_i(reg_wr),
        .reg_rd_i(reg_rd), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .irq_o(irq)
    );

    always #5 clk = ~clk;

    // User-mode vectors: run, high, low, edges to wait, expected word 0, expected word 1.
    localparam logic [31:0] VEC [0:4][0:5] = '{
        '{32'd1, 32'h0000_0000, 32'h0000_1000, 32'd12, 32'h0000_0000, 32'h0000_1600},
        '{32'd1, 32'h1234_5678, 32'hFFFF_FE00, 32'd4,  32'h1234_5679, 32'h0000_0000},
        '{32'd1, 32'hFFFF_FFFF, 32'hFFFF_FA00, 32'd12, 32'h8000_0000, 32'h0000_0200},
        '{32'd0, 32'h0000_0005, 32'h0000_0400, 32'd20, 32'h0000_0005, 32'h0000_0400},
        '{32'd0, 32'h0000_0ABC, 32'h0000_03FF, 32'd0,  32'h0000_0ABC, 32'h0000_0200}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(posedge clk); @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq", {31'd0, irq}, 32'd0);
        rd(3'd0, d); chk("R1 limit", d, 32'd0);
        rd(3'd3, d); chk("R1 run", d, 32'd1);
        rd(3'd5, d); chk("R12 word5 read", d, 32'd0);

        // R6: run cleared, counter mode still counts; R4 word1 ignored; R3 free-run
        wr(3'd3, 32'd0);
        rd(3'd3, d); chk("R6 run readback", d, 32'd0);
        wr(3'd0, 32'd0);
        wr(3'd1, 32'h0000_5000);
        wait_edges(7);
        rd(3'd1, d); chk("R2 R3 R4 R6 free-run count", d, 32'h0000_0400);
        wr(3'd6, 32'hFFFF_FFFF);
        rd(3'd0, d); chk("R12 limit untouched", d, 32'd0);
        rd(3'd3, d); chk("R12 run untouched", d, 32'd0);

        // R3 match timing, R5 reads
        wr(3'd0, 32'h0000_0800);
        wait_edges(15);
        chk("R3 irq before match", {31'd0, irq}, 32'd0);
        wait_edges(1);
        chk("R3 irq at match", {31'd0, irq}, 32'd1);
        rd(3'd1, d); chk("R5 count+reached", d, 32'h8000_0000);
        rd(3'd0, d); chk("R5 limit read", d, 32'h0000_0800);
        chk("R5 irq cleared", {31'd0, irq}, 32'd0);
        rd(3'd1, d); chk("R5 reached cleared", d, 32'd0);
        wait_edges(13);
        chk("R3 periodic match", {31'd0, irq}, 32'd1);

        // R10 enter user mode with run = 0
        user_mode = 1'b1;
        #1 chk("R10 irq held before edge", {31'd0, irq}, 32'd1);
        @(posedge clk); @(negedge clk);
        chk("R10 irq lowered", {31'd0, irq}, 32'd0);
        wait_edges(12);
        rd(3'd1, d); chk("R10 count kept and halted", d, 32'd0);
        rd(3'd0, d); chk("R7 high word with reached", d, 32'h8000_0000);
        rd(3'd0, d); chk("R7 read has no side effect", d, 32'h8000_0000);

        // R7 R8 R9 vector table
        for (int i = 0; i < 5; i++) begin
            wr(3'd3, VEC[i][0]);
            wr(3'd0, VEC[i][1]);
            wr(3'd1, VEC[i][2]);
            wait_edges(int'(VEC[i][3]));
            rd(3'd0, d); chk($sformatf("R8 R9 vec%0d word0", i), d, VEC[i][4]);
            rd(3'd1, d); chk($sformatf("R7 R8 vec%0d word1", i), d, VEC[i][5]);
            rd(3'd0, d); chk($sformatf("R7 vec%0d word0 again", i), d, VEC[i][4]);
            chk($sformatf("R9 vec%0d irq", i), {31'd0, irq}, 32'd0);
        end

        // R11 return to counter mode with run = 0
        user_mode = 1'b0;
        @(posedge clk); @(negedge clk);
        wait_edges(8);
        rd(3'd1, d); chk("R11 restarted count", d, 32'h0000_0400);
        rd(3'd0, d); chk("R10 forced limit", d, 32'h7FFF_FE00);

        // R4 word 2 keeps count and phase
        wr(3'd0, 32'h0000_1000);
        wait_edges(8);
        wr(3'd2, 32'h0000_0600);
        wait_edges(2);
        chk("R4 no early match", {31'd0, irq}, 32'd0);
        wait_edges(1);
        chk("R4 match after word2", {31'd0, irq}, 32'd1);
        rd(3'd0, d); chk("R4 word2 limit", d, 32'h0000_0600);

        // R4 limit mask, R6 run set
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, d); chk("R4 limit mask", d, 32'h7FFF_FE00);
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3, d); chk("R6 run set", d, 32'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule